// File: doc/BRIEF.md
# Edge-Sensing Interrupt Collector

This block watches a bank of input lines, by default sixteen, and drives one shared active-low interrupt request. Each line has a two-bit edge selector, so it can watch for rising edges, falling edges, both, or nothing. Each line also has a blocking bit. A line that shows a selected edge while unblocked latches a bit in a pending-event register. The interrupt request stays asserted while any pending bit is set.

The host reaches the three registers through a byte-wide port with a write strobe and a combinational read. It clears pending bits by writing ones to them. The inputs are asynchronous. They pass through a two-flop synchronizer, and a third flop holds the previous sample, so edges are found between consecutive synchronized samples.

The request output is controlled by a two-state machine. In `IRQ_IDLE` the output is high. It moves to `IRQ_PENDING` when at least one pending bit is set, and the output goes low. It returns to `IRQ_IDLE` in the first cycle after it sees the pending register all zero.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, every blocking bit is 1, every edge selector is 00, every pending bit is 0 and `irq_n` is high.
- R2: Selector code 01 latches the line's pending bit on a 0-to-1 input transition and ignores 1-to-0 transitions.
- R3: Selector code 10 latches the pending bit on a 1-to-0 transition and ignores 0-to-1 transitions.
- R4: Selector code 11 latches the pending bit on either transition.
- R5: Selector code 00 never latches the pending bit.
- R6: While a line's blocking bit is 1, edges on that line are not latched. Clearing the blocking bit later does not recover those edges.
- R7: A write to a pending-register byte clears exactly the bits written as 1 and leaves the other bits unchanged.
- R8: An input change that is present at clock edge k shows up in the pending register after edge k+2. `irq_n` then goes low after edge k+3 and stays low while any pending bit is set.
- R9: `irq_n` returns high one cycle after the write that clears the last pending bit.
- R10: If an enabled edge and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R11: The selector word occupies byte addresses 0 to 3. Line n's code sits at bits [2(n mod 4)+1 : 2(n mod 4)] of address 3 - n/4. Address 0 therefore holds lines 15 to 12 and address 3 holds lines 3 to 0.
- R12: The blocking register sits at addresses 4 and 5, and the pending register at addresses 6 and 7. In each pair, the lower address holds lines 15 to 8 (bit b = line 8+b) and the higher address holds lines 7 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | NUM_LINES | Asynchronous input lines |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wr | input | 1 | Write strobe; takes effect at the next clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach is the collision: a clearing write and a newly detected edge on the same line in the same cycle. From the ports, the edge is only visible through the synchronizer pipeline. The stimulus first latches the line, then changes the pin exactly two edges before the clearing write lands. The edge's detection cycle then coincides with the write. A similar cycle count places the checks on the request output one edge after the pending bit appears, and one edge after it is cleared.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

    typedef enum logic [0:0] {
        IRQ_IDLE    = 1'b0,
        IRQ_PENDING = 1'b1
    } irq_state_e;

    localparam logic [1:0] SEL_OFF  = 2'b00;
    localparam logic [1:0] SEL_RISE = 2'b01;
    localparam logic [1:0] SEL_FALL = 2'b10;
    localparam logic [1:0] SEL_BOTH = 2'b11;

endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise_o = sync_q & ~prev_q;
    assign fall_o = ~sync_q & prev_q;
endmodule

// File: rtl/edge_irq_regs.sv
module edge_irq_regs #(
    parameter int N  = 16,
    parameter int AW = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]   wdata_i,
    input  logic [N-1:0] rise_i,
    input  logic [N-1:0] fall_i,
    output logic [7:0]   rdata_o,
    output logic [N-1:0] src_o,
    output logic [N-1:0] mask_o,
    output logic [N-1:0] hit_o
);
    localparam int SEL_BYTES = N / 4;
    localparam int BIT_BYTES = N / 8;
    localparam int MASK_BASE = SEL_BYTES;
    localparam int SRC_BASE  = SEL_BYTES + BIT_BYTES;

    logic [2*N-1:0] sel_q;
    logic [N-1:0]   mask_q, src_q, clr;

    for (genvar n = 0; n < N; n++) begin : g_line
        assign hit_o[n] = ~mask_q[n] &
                          ((rise_i[n] & sel_q[2*n]) | (fall_i[n] & sel_q[2*n+1]));
    end

    always_comb begin
        clr = '0;
        for (int b = 0; b < BIT_BYTES; b++) begin
            if (wr_i && addr_i == AW'(SRC_BASE + b))
                clr[(BIT_BYTES-1-b)*8 +: 8] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            mask_q <= '1;
            src_q  <= '0;
        end else begin
            for (int b = 0; b < SEL_BYTES; b++) begin
                if (wr_i && addr_i == AW'(b))
                    sel_q[(SEL_BYTES-1-b)*8 +: 8] <= wdata_i;
            end
            for (int b = 0; b < BIT_BYTES; b++) begin
                if (wr_i && addr_i == AW'(MASK_BASE + b))
                    mask_q[(BIT_BYTES-1-b)*8 +: 8] <= wdata_i;
            end
            src_q <= (src_q & ~clr) | hit_o;
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int b = 0; b < SEL_BYTES; b++)
            if (addr_i == AW'(b)) rdata_o = sel_q[(SEL_BYTES-1-b)*8 +: 8];
        for (int b = 0; b < BIT_BYTES; b++) begin
            if (addr_i == AW'(MASK_BASE + b)) rdata_o = mask_q[(BIT_BYTES-1-b)*8 +: 8];
            if (addr_i == AW'(SRC_BASE + b))  rdata_o = src_q[(BIT_BYTES-1-b)*8 +: 8];
        end
    end

    assign src_o  = src_q;
    assign mask_o = mask_q;
endmodule

// File: rtl/edge_irq_fsm.sv
module edge_irq_fsm
    import edge_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    output logic irq_n_o
);
    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:    if (pending_i)  state_d = IRQ_PENDING;
            IRQ_PENDING: if (!pending_i) state_d = IRQ_IDLE;
            default:     state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            IRQ_PENDING: irq_n_o = 1'b0;
            default:     irq_n_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
    parameter int NUM_LINES = 16,
    parameter int ADDR_W    = $clog2(NUM_LINES / 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_i,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    output logic                 irq_n
);
    logic [NUM_LINES-1:0] rise_w, fall_w, src_w, mask_w, hit_w;

    edge_irq_sync #(.N(NUM_LINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (line_i),
        .rise_o (rise_w),
        .fall_o (fall_w)
    );

    edge_irq_regs #(.N(NUM_LINES), .AW(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .rise_i  (rise_w),
        .fall_i  (fall_w),
        .rdata_o (bus_rdata),
        .src_o   (src_w),
        .mask_o  (mask_w),
        .hit_o   (hit_w)
    );

    edge_irq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (|src_w),
        .irq_n_o   (irq_n)
    );
endmodule

// File: rtl/edge_irq_ctrl_chk.sv
module edge_irq_ctrl_chk #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         irq_n,
    input logic [N-1:0] src,
    input logic [N-1:0] mask,
    input logic [N-1:0] hit
);
    AST_IRQ_LOW_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (|src) |=> !irq_n); // R8

    AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (src == '0) |=> irq_n); // R9

    AST_BLOCKED_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((src & ~$past(src) & $past(mask)) == '0)); // R6

    AST_SET_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((src & ~$past(src) & ~$past(hit)) == '0)); // R5

    AST_EDGE_WINS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((src & $past(hit)) == $past(hit))); // R10
endmodule

bind edge_irq_ctrl edge_irq_ctrl_chk #(.N(NUM_LINES)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .irq_n (irq_n),
    .src   (src_w),
    .mask  (mask_w),
    .hit   (hit_w)
);

// File: tb/edge_irq_ctrl_tb.sv
module edge_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] line_i = '0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq_n;

    int errors = 0;
    int checks = 0;
    logic tb_rd = 1'b0;
    logic done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [2:0] addr_q[$];

    always #2 clk = ~clk;

    edge_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .line_i(line_i), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step(1);
        bus_wr = 1'b0;
    endtask

    // driver: pushes the expected value, the monitor compares at the falling edge
    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        bus_addr = a; exp_q.push_back(e); tag_q.push_back(tag); addr_q.push_back(a);
        tb_rd = 1'b1;
        step(1);
        tb_rd = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        checks++;
        if (irq_n !== e) begin
            errors++;
            $display("FAIL %s: irq_n actual=%b expected=%b", tag, irq_n, e);
        end
    endtask

    always @(negedge clk) begin
        if (tb_rd) begin
            logic [7:0] e;
            string t;
            logic [2:0] a;
            e = exp_q.pop_front(); t = tag_q.pop_front(); a = addr_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s: addr %0d actual=%h expected=%h", t, a, bus_rdata, e);
            end
        end
    end

    initial begin
        #150000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk_irq(1'b1, "R1");
        for (int a = 0; a < 4; a++) rd(3'(a), 8'h00, "R1 selector");
        rd(3'd4, 8'hFF, "R1 mask hi"); rd(3'd5, 8'hFF, "R1 mask lo");
        rd(3'd6, 8'h00, "R1 src hi");  rd(3'd7, 8'h00, "R1 src lo");

        // R11 selector layout: line15 both, line9 rise, line4 rise, line0 rise
        wr(3'd0, 8'hC0); wr(3'd1, 8'h04); wr(3'd2, 8'h01); wr(3'd3, 8'h01);
        rd(3'd0, 8'hC0, "R11 addr0"); rd(3'd1, 8'h04, "R11 addr1");
        rd(3'd2, 8'h01, "R11 addr2"); rd(3'd3, 8'h01, "R11 addr3");
        // R12 mask layout: unblock lines 15, 9 and 0
        wr(3'd4, 8'h7D); wr(3'd5, 8'hFE);
        rd(3'd4, 8'h7D, "R12 mask hi"); rd(3'd5, 8'hFE, "R12 mask lo");

        // R2 rising on line 0, R8 timing
        line_i[0] = 1'b1;
        step(3);
        chk_irq(1'b1, "R8 not yet");
        rd(3'd7, 8'h01, "R2 rise latched");
        chk_irq(1'b0, "R8 asserted");
        step(2);
        chk_irq(1'b0, "R8 held");
        // R9 release
        wr(3'd7, 8'h01);
        chk_irq(1'b0, "R9 one cycle late");
        step(1);
        chk_irq(1'b1, "R9 released");
        // R2 falling ignored
        line_i[0] = 1'b0;
        step(4);
        rd(3'd7, 8'h00, "R2 fall ignored");
        chk_irq(1'b1, "R2 no irq");

        // R3 line 9 falling only
        wr(3'd1, 8'h08);
        line_i[9] = 1'b1; step(4);
        rd(3'd6, 8'h00, "R3 rise ignored");
        line_i[9] = 1'b0; step(4);
        rd(3'd6, 8'h02, "R3 fall latched");

        // R4 line 15 both edges, R7 selective clear
        line_i[15] = 1'b1; step(4);
        rd(3'd6, 8'h82, "R4 rise latched");
        wr(3'd6, 8'h80);
        rd(3'd6, 8'h02, "R7 only written bit cleared");
        line_i[15] = 1'b0; step(4);
        rd(3'd6, 8'h82, "R4 fall latched");
        wr(3'd6, 8'h82);
        rd(3'd6, 8'h00, "R7 both cleared");
        step(1);
        chk_irq(1'b1, "R9 after clear");

        // R5 line 3 code 00 unblocked
        wr(3'd5, 8'hF6);
        line_i[3] = 1'b1; step(4); line_i[3] = 1'b0; step(4);
        rd(3'd7, 8'h00, "R5 disabled line");

        // R6 line 4 rising but blocked
        line_i[4] = 1'b1; step(4);
        rd(3'd7, 8'h00, "R6 blocked");
        chk_irq(1'b1, "R6 no irq");
        wr(3'd5, 8'hE6); step(2);
        rd(3'd7, 8'h00, "R6 not recovered");

        // R10 collision: latch line 0, then land a new edge on the clearing write
        line_i[0] = 1'b1; step(4);
        rd(3'd7, 8'h01, "R10 setup");
        line_i[0] = 1'b0; step(4);
        line_i[0] = 1'b1; step(2);
        wr(3'd7, 8'h01);
        rd(3'd7, 8'h01, "R10 edge wins");
        wr(3'd7, 8'h01);
        rd(3'd7, 8'h00, "R10 later clear");
        step(1);
        chk_irq(1'b1, "R9 final");

        step(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule